// File: doc/BRIEF.md
# Round-Robin Set-Associative Tag Directory

This block is the tag side of a set-associative cache. For every valid byte address it returns, one cycle later, whether the line is present. It also keeps running totals of hits and misses. The address is split into three fields: line offset, set index and tag. The tag is compared against every way of the selected set at once. Data, dirty state, write policy and refill traffic are not part of the block; only tags and valid bits are held.

On a miss the incoming tag is installed in the same cycle. Each set has two independent way pointers. The fill pointer places tags into empty ways in order. The victim pointer starts at way 0 after reset and moves on only when a full set has to give up a line. A single state register records the outcome of the last accepted request, and the outputs are decoded from it. The states are `ST_IDLE` (no request), `ST_HIT`, `ST_FILL` (miss into a free way) and `ST_EVICT` (miss into a full set). The transition taken every cycle depends only on the current request:
- no request goes to `ST_IDLE`;
- a matching valid way goes to `ST_HIT`;
- a miss with a free way goes to `ST_FILL`;
- a miss with every way valid goes to `ST_EVICT`.

The four sizing parameters are address width, line size, total lines and ways. Each must be a power of two, and the tag must keep at least one bit. When lines equal ways, the index is empty and every access goes to set 0. When ways equal 1, the store is direct-mapped.

Top module: `rr_tag_dir`

## Requirements
- R1: With the default sizing (16-bit address, 16-byte lines, 32 lines, 4 ways), the set index is address bits [6:4] and the tag is bits [15:7].
- R2: A request reports a hit when any valid way of its set holds its tag. A hit alters no tag, valid bit or pointer, so later accesses behave as if it had not happened.
- R3: A miss in a set with a free way writes the tag at that set's fill pointer, which then steps by one modulo the way count. The ways therefore fill 0, 1, 2, 3.
- R4: A miss in a full set overwrites the way at that set's victim pointer, which then steps by one modulo the way count. After reset the first eviction in a set replaces way 0, and evictions continue 1, 2, 3, 0.
- R5: `hit_count` rises by one for every hit and `miss_count` by one for every miss. Neither changes otherwise.
- R6: A synchronous reset clears both counters, every valid bit and every pointer, so the first access after reset is a miss.
- R7: `resp_valid` and `resp_hit` for a request sampled at one rising edge are visible after that edge, together with the updated counters. A request in the very next cycle already sees the tag installed by the previous one.
- R8: A cycle with `req_valid` low changes no state: `resp_valid` falls and both counters hold.
- R9: The offset bits [3:0] take no part in the lookup, so addresses that differ only there resolve to the same line.
- R10: Sets are independent: installs and evictions in one set leave the tags and pointers of every other set unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Lookup request this cycle |
| req_addr | input | ADDR_W | Byte address to look up |
| resp_valid | output | 1 | Result of last cycle's request is present |
| resp_hit | output | 1 | 1 = hit, 0 = miss (valid with resp_valid) |
| hit_count | output | CNT_W | Running hit total |
| miss_count | output | CNT_W | Running miss total |

## Verification
The case that is hardest to reach from the ports is the victim pointer's second lap in a set. A set must first fill completely and then take more evictions than it has ways. Random accesses spread over the sets seldom pile enough misses on one set to get there. A directed sequence therefore fills set 0, evicts through way 0 and onward, and re-reads the displaced and surviving tags. Random traffic then draws tags from a pool only slightly larger than the way count across all eight sets. This keeps every set full and turning its victim pointer many times, while also producing frequent hits. Every result is compared against a bench model of tags, valid bits and both pointers.

// File: rtl/rr_tag_pkg.sv
package rr_tag_pkg;

    // Outcome of the request sampled at the last clock edge
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_HIT   = 2'd1,
        ST_FILL  = 2'd2,
        ST_EVICT = 2'd3
    } acc_state_e;

endpackage

// File: rtl/rr_addr_split.sv
module rr_addr_split #(
    parameter int ADDR_W = 16,
    parameter int OFF_W  = 4,
    parameter int IDX_W  = 3,
    parameter int TAG_W  = 9,
    parameter int SET_W  = 3
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [SET_W-1:0]  set_sel,
    output logic [TAG_W-1:0]  tag
);

    assign tag = addr[ADDR_W-1 -: TAG_W];

    generate
        if (IDX_W == 0) begin : g_one_set
            assign set_sel = '0;
        end else begin : g_many_sets
            assign set_sel = addr[OFF_W +: IDX_W];
        end
    endgenerate

endmodule

// File: rtl/rr_way_match.sv
module rr_way_match #(
    parameter int WAYS  = 4,
    parameter int TAG_W = 9
) (
    input  logic [WAYS-1:0][TAG_W-1:0] way_tags,
    input  logic [WAYS-1:0]            way_valid,
    input  logic [TAG_W-1:0]           tag,
    output logic                       hit,
    output logic                       full
);

    logic [WAYS-1:0] match;

    generate
        for (genvar w = 0; w < WAYS; w++) begin : g_cmp
            assign match[w] = way_valid[w] && (way_tags[w] == tag);
        end
    endgenerate

    assign hit  = |match;
    assign full = &way_valid;

endmodule

// File: rtl/rr_tag_array.sv
module rr_tag_array #(
    parameter int SETS  = 8,
    parameter int WAYS  = 4,
    parameter int TAG_W = 9,
    parameter int SET_W = 3,
    parameter int WAY_W = 2
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic [SET_W-1:0]           set_sel,
    output logic [WAYS-1:0][TAG_W-1:0] rd_tags,
    output logic [WAYS-1:0]            rd_valid,
    input  logic                       wr_en,
    input  logic                       wr_evict,
    input  logic [TAG_W-1:0]           wr_tag
);

    localparam logic [WAY_W-1:0] LAST_WAY = WAY_W'(WAYS - 1);

    logic [WAYS-1:0][TAG_W-1:0] tag_mem  [SETS];
    logic [WAYS-1:0]            valid_q  [SETS];
    logic [WAY_W-1:0]           fill_q   [SETS];
    logic [WAY_W-1:0]           vict_q   [SETS];
    logic [WAY_W-1:0]           wr_way;

    function automatic logic [WAY_W-1:0] step_ptr(input logic [WAY_W-1:0] p);
        return (p == LAST_WAY) ? '0 : p + 1'b1;
    endfunction

    assign rd_tags  = tag_mem[set_sel];
    assign rd_valid = valid_q[set_sel];
    assign wr_way   = wr_evict ? vict_q[set_sel] : fill_q[set_sel];

    // Tags carry no reset; a way is only read once its valid bit is set
    always_ff @(posedge clk) begin
        if (wr_en) begin
            tag_mem[set_sel][wr_way] <= wr_tag;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < SETS; s++) begin
                valid_q[s] <= '0;
                fill_q[s]  <= '0;
                vict_q[s]  <= '0;
            end
        end else if (wr_en) begin
            valid_q[set_sel][wr_way] <= 1'b1;
            if (wr_evict) begin
                vict_q[set_sel] <= step_ptr(vict_q[set_sel]);
            end else begin
                fill_q[set_sel] <= step_ptr(fill_q[set_sel]);
            end
        end
    end

endmodule

// File: rtl/rr_tag_dir.sv
module rr_tag_dir
    import rr_tag_pkg::*;
#(
    parameter int ADDR_W     = 16,
    parameter int LINE_BYTES = 16,
    parameter int NUM_LINES  = 32,
    parameter int WAYS       = 4,
    parameter int CNT_W      = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              resp_valid,
    output logic              resp_hit,
    output logic [CNT_W-1:0]  hit_count,
    output logic [CNT_W-1:0]  miss_count
);

    localparam int SETS  = NUM_LINES / WAYS;
    localparam int OFF_W = $clog2(LINE_BYTES);
    localparam int IDX_W = $clog2(SETS);
    localparam int TAG_W = ADDR_W - IDX_W - OFF_W;
    localparam int SET_W = (IDX_W == 0) ? 1 : IDX_W;
    localparam int WAY_W = (WAYS == 1) ? 1 : $clog2(WAYS);

    logic [SET_W-1:0]           set_sel;
    logic [TAG_W-1:0]           req_tag;
    logic [WAYS-1:0][TAG_W-1:0] way_tags;
    logic [WAYS-1:0]            way_valid;
    logic                       any_hit;
    logic                       set_full;
    logic                       install;
    acc_state_e                 st_q;
    acc_state_e                 st_nxt;

    rr_addr_split #(
        .ADDR_W (ADDR_W),
        .OFF_W  (OFF_W),
        .IDX_W  (IDX_W),
        .TAG_W  (TAG_W),
        .SET_W  (SET_W)
    ) u_split (
        .addr    (req_addr),
        .set_sel (set_sel),
        .tag     (req_tag)
    );

    rr_tag_array #(
        .SETS  (SETS),
        .WAYS  (WAYS),
        .TAG_W (TAG_W),
        .SET_W (SET_W),
        .WAY_W (WAY_W)
    ) u_array (
        .clk      (clk),
        .rst      (rst),
        .set_sel  (set_sel),
        .rd_tags  (way_tags),
        .rd_valid (way_valid),
        .wr_en    (install),
        .wr_evict (set_full),
        .wr_tag   (req_tag)
    );

    rr_way_match #(
        .WAYS  (WAYS),
        .TAG_W (TAG_W)
    ) u_match (
        .way_tags  (way_tags),
        .way_valid (way_valid),
        .tag       (req_tag),
        .hit       (any_hit),
        .full      (set_full)
    );

    // Outcome classification of the current request
    always_comb begin
        if (!req_valid) begin
            st_nxt = ST_IDLE;
        end else if (any_hit) begin
            st_nxt = ST_HIT;
        end else if (set_full) begin
            st_nxt = ST_EVICT;
        end else begin
            st_nxt = ST_FILL;
        end
    end

    assign install = (st_nxt == ST_FILL) || (st_nxt == ST_EVICT);

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= ST_IDLE;
        end else begin
            st_q <= st_nxt;
        end
    end

    // Running totals, updated at the same edge as the state
    always_ff @(posedge clk) begin
        if (rst) begin
            hit_count  <= '0;
            miss_count <= '0;
        end else if (st_nxt == ST_HIT) begin
            hit_count  <= hit_count + 1'b1;
        end else if (install) begin
            miss_count <= miss_count + 1'b1;
        end
    end

    // Output decode
    always_comb begin
        unique case (st_q)
            ST_IDLE:  begin resp_valid = 1'b0; resp_hit = 1'b0; end
            ST_HIT:   begin resp_valid = 1'b1; resp_hit = 1'b1; end
            ST_FILL:  begin resp_valid = 1'b1; resp_hit = 1'b0; end
            ST_EVICT: begin resp_valid = 1'b1; resp_hit = 1'b0; end
            default:  begin resp_valid = 1'b0; resp_hit = 1'b0; end
        endcase
    end

endmodule

// File: rtl/rr_tag_dir_chk.sv
module rr_tag_dir_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             req_valid,
    input logic             resp_valid,
    input logic             resp_hit,
    input logic [CNT_W-1:0] hit_count,
    input logic [CNT_W-1:0] miss_count
);

    logic [CNT_W-1:0] hit_prev;
    logic [CNT_W-1:0] miss_prev;
    logic [1:0]       reqs_seen;

    always_ff @(posedge clk) begin
        hit_prev  <= hit_count;
        miss_prev <= miss_count;
        if (rst) begin
            reqs_seen <= 2'd0;
        end else if (req_valid && reqs_seen != 2'd3) begin
            reqs_seen <= reqs_seen + 2'd1;
        end
    end

    assert_resp_timing_R7: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !rst) |=> resp_valid);

    assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (rst)
        (!req_valid && !rst) |=> (!resp_valid && $stable(hit_count) && $stable(miss_count)));

    assert_hit_count_R5: assert property (@(posedge clk) disable iff (rst)
        (resp_valid && resp_hit) |-> (hit_count == hit_prev + 1'b1 && miss_count == miss_prev));

    assert_miss_count_R5: assert property (@(posedge clk) disable iff (rst)
        (resp_valid && !resp_hit) |-> (miss_count == miss_prev + 1'b1 && hit_count == hit_prev));

    assert_empty_after_reset_R6: assert property (@(posedge clk) disable iff (rst)
        (resp_valid && reqs_seen == 2'd1) |-> !resp_hit);

endmodule

bind rr_tag_dir rr_tag_dir_chk #(.CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .req_valid  (req_valid),
    .resp_valid (resp_valid),
    .resp_hit   (resp_hit),
    .hit_count  (hit_count),
    .miss_count (miss_count)
);

// File: tb/rr_tag_dir_bench.sv
module rr_tag_dir_bench;

    localparam int NSETS = 8;
    localparam int NW    = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic [15:0] req_addr = '0;
    logic        resp_valid;
    logic        resp_hit;
    logic [15:0] hit_count;
    logic [15:0] miss_count;

    int checks = 0;
    int errors = 0;

    // Reference model
    int m_tag  [NSETS][NW];
    bit m_val  [NSETS][NW];
    int m_fill [NSETS];
    int m_vict [NSETS];
    int m_hits;
    int m_miss;

    rr_tag_dir u_rr_tag_dir (
        .clk        (clk),
        .rst        (rst),
        .req_valid  (req_valid),
        .req_addr   (req_addr),
        .resp_valid (resp_valid),
        .resp_hit   (resp_hit),
        .hit_count  (hit_count),
        .miss_count (miss_count)
    );

    always #5 clk = ~clk;

    function automatic logic [15:0] mk(input int tg, input int st, input int off);
        return {tg[8:0], st[2:0], off[3:0]};
    endfunction

    function automatic void model_reset();
        for (int s = 0; s < NSETS; s++) begin
            for (int w = 0; w < NW; w++) begin
                m_val[s][w] = 1'b0;
                m_tag[s][w] = 0;
            end
            m_fill[s] = 0;
            m_vict[s] = 0;
        end
        m_hits = 0;
        m_miss = 0;
    endfunction

    // R1 field split; R2 hit; R3 fill order; R4 victim order
    function automatic bit model_step(input logic [15:0] a);
        int  s;
        int  tg;
        int  w;
        bit  full;
        s  = int'(a[6:4]);
        tg = int'(a[15:7]);
        for (int i = 0; i < NW; i++) begin
            if (m_val[s][i] && m_tag[s][i] == tg) begin
                m_hits++;
                return 1'b1;
            end
        end
        full = 1'b1;
        for (int i = 0; i < NW; i++) if (!m_val[s][i]) full = 1'b0;
        if (full) begin
            w = m_vict[s];
            m_vict[s] = (m_vict[s] + 1) % NW;
        end else begin
            w = m_fill[s];
            m_fill[s] = (m_fill[s] + 1) % NW;
        end
        m_tag[s][w] = tg;
        m_val[s][w] = 1'b1;
        m_miss++;
        return 1'b0;
    endfunction

    task automatic check(input string rid, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", rid, what, act, exp);
        end
    endtask

    task automatic check_counts(input string rid);
        check(rid, "hit_count", int'(hit_count), m_hits & 16'hFFFF);
        check(rid, "miss_count", int'(miss_count), m_miss & 16'hFFFF);
    endtask

    task automatic access(input logic [15:0] a, input string rid);
        bit exp_hit;
        req_valid = 1'b1;
        req_addr  = a;
        exp_hit   = model_step(a);
        @(negedge clk);
        req_valid = 1'b0;
        check("R7", "resp_valid", int'(resp_valid), 1);
        check(rid, "resp_hit", int'(resp_hit), int'(exp_hit));
        check_counts("R5");
    endtask

    task automatic idle_cycle();
        req_valid = 1'b0;
        req_addr  = 16'($urandom);
        @(negedge clk);
        check("R8", "resp_valid", int'(resp_valid), 0);
        check_counts("R8");
    endtask

    task automatic do_reset();
        rst = 1'b1;
        req_valid = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        model_reset();
        check("R6", "resp_valid", int'(resp_valid), 0);
        check_counts("R6");
    endtask

    initial begin
        #1ms;
        errors++;
        $display("FAIL watchdog run did not finish actual=timeout expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        model_reset();
        @(negedge clk);
        do_reset();

        // R6 first access misses; R9 offset ignored
        access(mk(1, 0, 0), "R6");
        access(mk(1, 0, 15), "R9");
        access(mk(1, 0, 7), "R9");

        // R3 fill ways in order, back to back
        access(mk(2, 0, 0), "R3");
        access(mk(3, 0, 0), "R3");
        access(mk(4, 0, 0), "R3");
        // R2 hits change nothing
        access(mk(4, 0, 1), "R2");
        access(mk(1, 0, 2), "R2");
        access(mk(3, 0, 3), "R2");

        // R4 first eviction replaces way 0 (tag 1)
        access(mk(5, 0, 0), "R4");
        access(mk(2, 0, 0), "R4");    // still present
        access(mk(1, 0, 0), "R4");    // gone, now evicts way 1 (tag 2)
        access(mk(3, 0, 0), "R4");
        access(mk(2, 0, 0), "R4");    // gone, evicts way 2 (tag 3)
        access(mk(4, 0, 0), "R4");    // evicted way is not way 3
        access(mk(6, 0, 0), "R4");    // evicts way 3 (tag 4)
        access(mk(7, 0, 0), "R4");    // wraps to way 0 (tag 5)
        access(mk(5, 0, 0), "R4");
        access(mk(1, 0, 0), "R4");

        // R10 other sets untouched; R1 index bits
        access(mk(1, 3, 0), "R10");
        access(mk(1, 3, 9), "R10");
        access(mk(1, 5, 0), "R1");
        access(mk(1, 3, 0), "R1");

        // R8 idle cycles
        idle_cycle();
        idle_cycle();
        access(mk(1, 5, 4), "R8");

        // Mixed random traffic with a small tag pool
        for (int n = 0; n < 4000; n++) begin
            if ($urandom_range(9) < 8) begin
                access(mk($urandom_range(5), $urandom_range(7), $urandom_range(15)), "R4");
            end else begin
                idle_cycle();
            end
        end

        // R6 reset mid-run clears everything
        access(mk(2, 2, 0), "R2");
        access(mk(2, 2, 0), "R2");
        do_reset();
        access(mk(2, 2, 0), "R6");
        access(mk(2, 2, 0), "R6");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule